// File: doc/BRIEF.md
# Inter-Iteration Dependency Profiling Bank

This block watches one candidate loop while it runs sequentially and gathers the numbers needed to judge whether its iterations could run as speculative threads. The executing code marks loop entry, each iteration boundary and loop exit with single-cycle annotation pulses. Between those pulses the block snoops a stream of load and store line addresses.

Every store is stamped with the current iteration number and the loop-relative cycle time. The stamps go into a small direct-mapped store-timestamp table, which stands in for the buffer storage that holds speculative writes. A load that finds a store from an earlier iteration at its address counts as a cross-iteration dependency arc. The cycle distance back to that store is added to a running sum. Separately, the block counts the distinct lines stored within the current iteration. It records an overflow event the first time that count goes past a programmable capacity limit.

Three saturating counters hold the results. Software reads them through a small address/data read port. Arming for a new loop clears the counters and the table, so the bank traces exactly one loop at a time.

Top module: `iter_dep_profiler`

## Requirements
- R1: After reset the bank is disarmed and every readable counter reads zero.
- R2: A `loopEnter` pulse arms the bank, invalidates all table entries, zeroes the three counters, and sets the iteration number and the loop cycle time to 0. A `loopExit` pulse disarms it. While disarmed, loads and stores change neither the table nor any counter.
- R3: In a cycle where any annotation input is high, the memory input is ignored entirely.
- R4: A store sets the table entry selected by address bits [IDX_W-1:0] to the remaining upper bits as its tag, plus the current iteration number and the current cycle time. This replaces whatever that entry held. The cycle time advances by one in every armed cycle after the entering cycle, so the first armed cycle is time 0.
- R5: A load whose entry is valid, whose tag matches, and whose stored iteration is lower than the current iteration increments the arc counter by one.
- R6: On each counted arc, the distance sum grows by the current cycle time minus the stored cycle time.
- R7: A load that matches a store from the current iteration, or that misses on tag, counts no arc and adds no distance.
- R8: A store is a new line unless its entry already holds the same line stamped with the current iteration. New lines raise a per-iteration line count, and `iterNext` clears that count. The overflow counter increments once, on the new line that takes the count above `ovfLimit`.
- R9: All three counters saturate at their all-ones value.
- R10: Read address 0 returns the arc count, 1 the distance sum, 2 the overflow count, and 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| loopEnter | input | 1 | Annotation: traced loop begins |
| iterNext | input | 1 | Annotation: iteration boundary |
| loopExit | input | 1 | Annotation: traced loop ends |
| memValid | input | 1 | A memory access is presented this cycle |
| memIsStore | input | 1 | 1 = store, 0 = load |
| memAddr | input | ADDR_W | Line address of the access |
| ovfLimit | input | CNT_W | Allowed distinct store lines per iteration |
| rdAddr | input | 2 | Counter select for readout |
| rdData | output | CNT_W | Selected counter value |

## Verification
A wrong internal state surfaces only through the counters. A corrupt stored iteration or tag appears as a missing or extra arc on the very next load to that line, visible one clock later. A corrupt cycle stamp shows up as a distance sum that is off by a known amount after the first arc. A line count that is not cleared at iteration boundaries shows as an early overflow on the first store of the following iteration. The stimulus therefore places loads right after the events under test and reads all counters after every operation.

// File: rtl/ipb_pkg.sv
package ipb_pkg;
  // strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic clrAll;    // loop entry: clear table and counters
    logic wrEntry;   // store accepted: write timestamp entry
    logic countArc;  // load found an earlier-iteration store
    logic bumpOvf;   // per-iteration line budget just exceeded
  } ipbStrobe_t;
endpackage

// File: rtl/ipb_table.sv
module ipb_table #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int ITER_W = 8,
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clr,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ITER_W-1:0] curIter,
  input  logic [TIME_W-1:0] curTime,
  output logic              hitTag,
  output logic [ITER_W-1:0] hitIter,
  output logic [TIME_W-1:0] hitTime
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = ADDR_W - IDX_W;

  logic [ENTRIES-1:0] validQ;
  logic [TAG_W-1:0]   tagQ  [ENTRIES];
  logic [ITER_W-1:0]  iterQ [ENTRIES];
  logic [TIME_W-1:0]  timeQ [ENTRIES];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  assign idx = addr[IDX_W-1:0];
  assign tag = addr[ADDR_W-1:IDX_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         validQ <= '0;
    else if (clr)      validQ <= '0;
    else if (wr)       validQ[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr && !clr) begin
      tagQ[idx]  <= tag;
      iterQ[idx] <= curIter;
      timeQ[idx] <= curTime;
    end
  end

  assign hitTag  = validQ[idx] && (tagQ[idx] == tag);
  assign hitIter = iterQ[idx];
  assign hitTime = timeQ[idx];

  // R2: loop entry leaves no valid entry behind
  a_r2_table_cleared: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> ($countones(validQ) == 0));

  // R4: a write makes its entry valid
  a_r4_write_valid: assert property (@(posedge clk) disable iff (!rstN)
    (wr && !clr) |=> validQ[$past(idx)]);
endmodule

// File: rtl/ipb_ctrl.sv
module ipb_ctrl
  import ipb_pkg::*;
#(
  parameter int ITER_W = 8,
  parameter int TIME_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loopEnter,
  input  logic              iterNext,
  input  logic              loopExit,
  input  logic              memValid,
  input  logic              memIsStore,
  input  logic [CNT_W-1:0]  ovfLimit,
  input  logic              hitTag,
  input  logic [ITER_W-1:0] hitIter,
  input  logic [TIME_W-1:0] hitTime,
  output ipbStrobe_t        strobe,
  output logic [ITER_W-1:0] curIter,
  output logic [TIME_W-1:0] curTime,
  output logic [TIME_W-1:0] arcDist
);
  logic              armedQ;
  logic [ITER_W-1:0] iterQ;
  logic [TIME_W-1:0] timeQ;
  logic [CNT_W-1:0]  lineQ;

  logic anyAnn, memOk, sameLine, newLine, lineFull;

  assign anyAnn   = loopEnter | iterNext | loopExit;
  assign memOk    = armedQ & memValid & ~anyAnn;
  assign sameLine = hitTag && (hitIter == iterQ);
  assign lineFull = (lineQ == {CNT_W{1'b1}});

  always_comb begin
    strobe          = '0;
    strobe.clrAll   = loopEnter;
    strobe.wrEntry  = memOk & memIsStore;
    strobe.countArc = memOk & ~memIsStore & hitTag & (hitIter < iterQ);
    newLine         = strobe.wrEntry & ~sameLine;
    strobe.bumpOvf  = newLine & (lineQ == ovfLimit) & ~lineFull;
  end

  assign arcDist = timeQ - hitTime;
  assign curIter = iterQ;
  assign curTime = timeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= 1'b0;
      iterQ  <= '0;
      timeQ  <= '0;
      lineQ  <= '0;
    end else if (loopEnter) begin
      armedQ <= 1'b1;
      iterQ  <= '0;
      timeQ  <= '0;
      lineQ  <= '0;
    end else if (loopExit) begin
      armedQ <= 1'b0;
    end else if (armedQ) begin
      if (timeQ != {TIME_W{1'b1}}) timeQ <= timeQ + 1'b1;
      if (iterNext) begin
        if (iterQ != {ITER_W{1'b1}}) iterQ <= iterQ + 1'b1;
        lineQ <= '0;
      end else if (newLine && !lineFull) begin
        lineQ <= lineQ + 1'b1;
      end
    end
  end

  // R2: nothing reaches the datapath while disarmed
  a_r2_quiet_disarmed: assert property (@(posedge clk) disable iff (!rstN)
    !armedQ |-> (!strobe.wrEntry && !strobe.countArc && !strobe.bumpOvf));

  // R3: annotation cycles swallow the memory input
  a_r3_ann_masks_mem: assert property (@(posedge clk) disable iff (!rstN)
    (iterNext || loopExit) |-> (!strobe.wrEntry && !strobe.countArc));

  // R8: the budget is crossed at most once in a row
  a_r8_ovf_single: assert property (@(posedge clk) disable iff (!rstN)
    strobe.bumpOvf |=> !strobe.bumpOvf);

  // R5: iteration boundary advances the iteration number
  a_r5_iter_step: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && iterNext && !loopEnter && !loopExit) |=>
      (iterQ == $past(iterQ) + 1'b1 || iterQ == {ITER_W{1'b1}}));

  // R4: armed time runs forward by one per cycle
  a_r4_time_step: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && !anyAnn) |=>
      (timeQ == $past(timeQ) + 1'b1 || timeQ == {TIME_W{1'b1}}));
endmodule

// File: rtl/ipb_stats.sv
module ipb_stats
  import ipb_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ipbStrobe_t        strobe,
  input  logic [TIME_W-1:0] arcDist,
  input  logic [1:0]        rdAddr,
  output logic [CNT_W-1:0]  rdData
);
  localparam int SUM_W = ((CNT_W > TIME_W) ? CNT_W : TIME_W) + 1;
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CNT_W-1:0] arcQ, distQ, ovfQ;
  logic [SUM_W-1:0] distSum;

  assign distSum = SUM_W'(distQ) + SUM_W'(arcDist);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arcQ  <= '0;
      distQ <= '0;
      ovfQ  <= '0;
    end else if (strobe.clrAll) begin
      arcQ  <= '0;
      distQ <= '0;
      ovfQ  <= '0;
    end else begin
      if (strobe.countArc) begin
        if (arcQ != MAXV) arcQ <= arcQ + 1'b1;
        distQ <= (distSum > SUM_W'(MAXV)) ? MAXV : distSum[CNT_W-1:0];
      end
      if (strobe.bumpOvf && ovfQ != MAXV) ovfQ <= ovfQ + 1'b1;
    end
  end

  always_comb begin
    unique case (rdAddr)
      2'd0:    rdData = arcQ;
      2'd1:    rdData = distQ;
      2'd2:    rdData = ovfQ;
      default: rdData = '0;
    endcase
  end

  // R9: counters never wrap back down outside a clear
  a_r9_arc_monotonic: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clrAll |=> (arcQ >= $past(arcQ)));

  // R6: the distance sum only moves on a counted arc
  a_r6_dist_on_arc: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.countArc && !strobe.clrAll) |=> $stable(distQ));

  // R8: overflow count steps by at most one
  a_r8_ovf_step: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clrAll |=> (ovfQ == $past(ovfQ) || ovfQ == $past(ovfQ) + 1'b1));
endmodule

// File: rtl/iter_dep_profiler.sv
module iter_dep_profiler
  import ipb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int ITER_W = 8,
  parameter int TIME_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loopEnter,
  input  logic              iterNext,
  input  logic              loopExit,
  input  logic              memValid,
  input  logic              memIsStore,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [CNT_W-1:0]  ovfLimit,
  input  logic [1:0]        rdAddr,
  output logic [CNT_W-1:0]  rdData
);
  ipbStrobe_t        strobe;
  logic              hitTag;
  logic [ITER_W-1:0] hitIter, curIter;
  logic [TIME_W-1:0] hitTime, curTime, arcDist;

  ipb_ctrl #(.ITER_W(ITER_W), .TIME_W(TIME_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .loopEnter(loopEnter), .iterNext(iterNext), .loopExit(loopExit),
    .memValid(memValid), .memIsStore(memIsStore), .ovfLimit(ovfLimit),
    .hitTag(hitTag), .hitIter(hitIter), .hitTime(hitTime),
    .strobe(strobe), .curIter(curIter), .curTime(curTime), .arcDist(arcDist)
  );

  ipb_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ITER_W(ITER_W), .TIME_W(TIME_W)) uTable (
    .clk(clk), .rstN(rstN),
    .clr(strobe.clrAll), .wr(strobe.wrEntry), .addr(memAddr),
    .curIter(curIter), .curTime(curTime),
    .hitTag(hitTag), .hitIter(hitIter), .hitTime(hitTime)
  );

  ipb_stats #(.CNT_W(CNT_W), .TIME_W(TIME_W)) uStats (
    .clk(clk), .rstN(rstN), .strobe(strobe), .arcDist(arcDist),
    .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: tb/sim_iter_dep_profiler.sv
`timescale 1ns/100ps
module sim_iter_dep_profiler;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loopEnter = 0, iterNext = 0, loopExit = 0, memValid = 0, memIsStore = 0;
  logic [15:0] memAddr = '0;
  logic [CW-1:0] ovfLimit = 8'd2;
  logic [1:0] rdAddr = '0;
  logic [CW-1:0] rdData;

  int nTests = 0;
  int nFail = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  iter_dep_profiler #(.CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .loopEnter(loopEnter), .iterNext(iterNext),
    .loopExit(loopExit), .memValid(memValid), .memIsStore(memIsStore),
    .memAddr(memAddr), .ovfLimit(ovfLimit), .rdAddr(rdAddr), .rdData(rdData)
  );

  // op codes: 0 idle, 1 enter, 2 next, 3 exit, 4 store, 5 load
  // vector: {op, addr, expArcs, expDist, expOvf}; limit 2
  localparam int NV = 17;
  localparam logic [34:0] VEC [NV] = '{
    {3'd1, 8'h00, 8'd0, 8'd0,  8'd0},  // R2 enter
    {3'd4, 8'h05, 8'd0, 8'd0,  8'd0},  // R4 store t0
    {3'd5, 8'h05, 8'd0, 8'd0,  8'd0},  // R7 same-iteration load
    {3'd4, 8'h15, 8'd0, 8'd0,  8'd0},  // R4 replaces entry 5, t2
    {3'd4, 8'h07, 8'd0, 8'd0,  8'd1},  // R8 third line > limit, t3
    {3'd4, 8'h08, 8'd0, 8'd0,  8'd1},  // R8 counted once only
    {3'd2, 8'h00, 8'd0, 8'd0,  8'd1},  // iteration 1
    {3'd5, 8'h05, 8'd0, 8'd0,  8'd1},  // R7 tag miss after replace
    {3'd5, 8'h15, 8'd1, 8'd5,  8'd1},  // R5 R6 t7-t2
    {3'd5, 8'h07, 8'd2, 8'd10, 8'd1},  // R6 t8-t3
    {3'd4, 8'h07, 8'd2, 8'd10, 8'd1},  // restamp in iteration 1
    {3'd5, 8'h07, 8'd2, 8'd10, 8'd1},  // R7 now same iteration
    {3'd3, 8'h00, 8'd2, 8'd10, 8'd1},  // exit
    {3'd5, 8'h08, 8'd2, 8'd10, 8'd1},  // R2 disarmed load ignored
    {3'd4, 8'h09, 8'd2, 8'd10, 8'd1},  // R2 disarmed store ignored
    {3'd1, 8'h00, 8'd0, 8'd0,  8'd0},  // R2 counters cleared
    {3'd5, 8'h08, 8'd0, 8'd0,  8'd0}   // R2 table cleared
  };

  task automatic check(input logic [1:0] a, input logic [CW-1:0] exp, input string req);
    rdAddr = a;
    #0.1;
    nTests++;
    if (rdData !== exp) begin
      nFail++;
      $display("FAIL %s addr %0d: got %0d expected %0d", req, a, rdData, exp);
    end
  endtask

  // drive one op for exactly one cycle; returns at the following negedge
  task automatic doOp(input logic [2:0] op, input logic [7:0] a);
    loopEnter  = (op == 3'd1);
    iterNext   = (op == 3'd2);
    loopExit   = (op == 3'd3);
    memValid   = (op == 3'd4) || (op == 3'd5);
    memIsStore = (op == 3'd4);
    memAddr    = {8'h00, a};
    @(negedge clk);
    loopEnter = 0; iterNext = 0; loopExit = 0; memValid = 0; memIsStore = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(2'd0, 8'd0, "R1");
    check(2'd1, 8'd0, "R1");
    check(2'd2, 8'd0, "R1");
    rstN = 1'b1;
    @(negedge clk);
    // R2: disarmed after reset, traffic ignored
    doOp(3'd4, 8'h33);
    doOp(3'd5, 8'h33);
    check(2'd0, 8'd0, "R2");

    for (int i = 0; i < NV; i++) begin
      doOp(VEC[i][34:32], VEC[i][31:24]);
      check(2'd0, VEC[i][23:16], $sformatf("R5 arcs vec%0d", i));
      check(2'd1, VEC[i][15:8],  $sformatf("R6 dist vec%0d", i));
      check(2'd2, VEC[i][7:0],   $sformatf("R8 ovf vec%0d", i));
    end
    check(2'd3, 8'd0, "R10");

    // R3 and R8 with limit 0
    ovfLimit = 8'd0;
    doOp(3'd1, 8'h00);
    iterNext = 1; memValid = 1; memIsStore = 1; memAddr = 16'h0003;
    @(negedge clk);
    iterNext = 0; memValid = 0; memIsStore = 0;
    check(2'd2, 8'd0, "R3");
    doOp(3'd4, 8'h03);
    check(2'd2, 8'd1, "R8");
    doOp(3'd4, 8'h03);
    check(2'd2, 8'd1, "R8");
    doOp(3'd2, 8'h00);
    doOp(3'd4, 8'h03);
    check(2'd2, 8'd2, "R8");

    // R6 distance then R9 saturation
    ovfLimit = 8'd2;
    doOp(3'd1, 8'h00);
    doOp(3'd4, 8'h2A);  // t0
    doOp(3'd2, 8'h00);  // t1
    for (int k = 0; k < 60; k++) doOp(3'd0, 8'h00);
    doOp(3'd5, 8'h2A);  // t62
    check(2'd0, 8'd1, "R5");
    check(2'd1, 8'd62, "R6");
    for (int k = 0; k < 300; k++) doOp(3'd5, 8'h2A);
    check(2'd0, 8'hFF, "R9");
    check(2'd1, 8'hFF, "R9");
    check(2'd3, 8'd0, "R10");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule